// File: doc/BRIEF.md
# NAND Command and Address Front End

This block sits on the device side of a small-page NAND memory bus and decides what each write cycle on the 8-bit I/O bus carries. It watches the write-enable line and acts on each rising edge that occurs while chip enable is low and read enable is high. At that edge the command-latch and address-latch strobes mark the byte as an opcode, an address byte or a data byte. Every input is sampled on the system clock, and a rising write-enable edge is found as a low-to-high change between two samples.

Address bytes arrive in three consecutive cycles and are assembled into a 24-bit address. The block number sits at bits 23..14, the page within the block at bits 13..9, a half-page pointer at bit 8 and the column at bits 7..0. The bus never carries bit 8. It comes from the most recent pointer command. A downstream sequencer receives three things: a one-cycle command strobe with its opcode, and a one-cycle data strobe that carries the byte and its position in the 528-byte page. It also receives sticky flags for a malformed address, extra address bytes and write-protect inhibit. A busy input from that sequencer blocks further input while a program or erase is in progress.

Top module: `nand_cmd_addr_latch`

## Requirements
- R1: A write cycle with cle=1, ale=0 is a command. Unless R6 or R7 blocks it, `cmd_stb` is high for one clock with `cmd_op` equal to the byte. The command also resets the address count to zero and clears `addr_valid`, `addr_err`, `addr_ovf` and `inhibit`.
- R2: Write cycles with cle=0, ale=1 are address bytes. The first byte goes to addr[7:0] and the second to addr[16:9]. Bits 6..0 of the third byte go to addr[23:17], and `addr_valid` then rises.
- R3: If bit 7 of the third address byte is 1, `addr_err` is set. It stays set until the next accepted command.
- R4: Opcode 00h clears the half-page pointer and opcode 01h sets it. The pointer is 0 after reset. It is copied into addr[8] when the first address byte is taken.
- R5: Once three address bytes have been taken, further address bytes leave `addr` unchanged and set `addr_ovf`.
- R6: While wp_n is 0, the opcodes 80h, 10h, 60h and D0h produce no `cmd_stb` and change no state, and they set `inhibit`.
- R7: While busy is 1, address bytes, data bytes and all opcodes other than FFh and 70h are ignored. FFh and 70h are still accepted.
- R8: Opcode FFh also returns the half-page pointer to 0, in addition to the effects in R1.
- R9: A write cycle with cle=0, ale=0 is data. It gives `din_stb` with `din_byte` equal to the byte, but only while `addr_valid` is 1. `din_col` starts at pointer*256 plus the first address byte, rises by one per data byte and stops at 527.
- R10: Write cycles with ce_n=1 or re_n=0 are ignored entirely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Command latch strobe |
| ale | input | 1 | Address latch strobe |
| we_n | input | 1 | Write enable, bytes taken on its rising edge |
| re_n | input | 1 | Read enable, active low |
| wp_n | input | 1 | Write protect, active low |
| busy | input | 1 | Program or erase in progress |
| io | input | 8 | Bus byte |
| cmd_stb | output | 1 | One-cycle accepted-command strobe |
| cmd_op | output | 8 | Opcode of the last accepted command |
| addr | output | 24 | Assembled address |
| addr_valid | output | 1 | Three address bytes have been taken |
| din_stb | output | 1 | One-cycle data byte strobe |
| din_byte | output | 8 | Data byte |
| din_col | output | 10 | Page column of the data byte |
| addr_err | output | 1 | Reserved bit of the third address byte was set |
| addr_ovf | output | 1 | More than three address bytes were sent |
| inhibit | output | 1 | Program or erase was blocked by write protect |

## Verification
An error in the address count shows up in the clock right after the edge that triggered it. Bytes land in the wrong field of `addr`, or `addr_valid` rises one byte early or late. A half-page pointer that is not updated shows up in addr[8] and in the starting `din_col` after the next address sequence. A wrong column counter shows as a `din_col` that does not follow the expected sequence or runs past 527 during a long data burst. A busy or write-protect gate that leaks shows as a strobe on the clock after an edge that should have been ignored.

// File: rtl/nand_cmd_addr_latch.sv
module nand_cmd_addr_latch #(
  parameter int IO_W       = 8,
  parameter int ADDR_CYC   = 3,
  parameter int PAGE_BYTES = 528
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ce_n,
  input  logic                     cle,
  input  logic                     ale,
  input  logic                     we_n,
  input  logic                     re_n,
  input  logic                     wp_n,
  input  logic                     busy,
  input  logic [IO_W-1:0]          io,
  output logic                     cmd_stb,
  output logic [IO_W-1:0]          cmd_op,
  output logic [IO_W*ADDR_CYC-1:0] addr,
  output logic                     addr_valid,
  output logic                     din_stb,
  output logic [IO_W-1:0]          din_byte,
  output logic [$clog2(PAGE_BYTES)-1:0] din_col,
  output logic                     addr_err,
  output logic                     addr_ovf,
  output logic                     inhibit
);
  localparam int AW    = IO_W * ADDR_CYC;
  localparam int COL_W = $clog2(PAGE_BYTES);
  localparam int CNT_W = $clog2(ADDR_CYC + 1);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(PAGE_BYTES - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(ADDR_CYC);

  logic             we_low_q;
  logic             a8;
  logic [CNT_W-1:0] cnt;
  logic [COL_W-1:0] col_ptr;

  wire wr     = we_low_q & we_n & ~ce_n & re_n;
  wire is_cmd = wr &  cle & ~ale;
  wire is_adr = wr & ~cle &  ale;
  wire is_dat = wr & ~cle & ~ale;

  wire pe_op   = (io == 8'h80) | (io == 8'h10) | (io == 8'h60) | (io == 8'hD0);
  wire busy_ok = (io == 8'hFF) | (io == 8'h70);
  wire blocked = pe_op & ~wp_n;

  wire cmd_go  = is_cmd & (~busy | busy_ok) & ~blocked;
  wire cmd_inh = is_cmd & ~busy & blocked;
  wire adr_go  = is_adr & ~busy;
  wire dat_go  = is_dat & ~busy & addr_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_low_q <= 1'b0;
    else        we_low_q <= ~we_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_stb    <= 1'b0;
      cmd_op     <= '0;
      addr       <= '0;
      addr_valid <= 1'b0;
      din_stb    <= 1'b0;
      din_byte   <= '0;
      din_col    <= '0;
      addr_err   <= 1'b0;
      addr_ovf   <= 1'b0;
      inhibit    <= 1'b0;
      a8         <= 1'b0;
      cnt        <= '0;
      col_ptr    <= '0;
    end else begin
      cmd_stb <= 1'b0;
      din_stb <= 1'b0;
      if (cmd_go) begin
        cmd_stb    <= 1'b1;
        cmd_op     <= io;
        cnt        <= '0;
        addr_valid <= 1'b0;
        addr_err   <= 1'b0;
        addr_ovf   <= 1'b0;
        inhibit    <= 1'b0;
        if (io == 8'h00 || io == 8'hFF) a8 <= 1'b0;
        if (io == 8'h01)                a8 <= 1'b1;
      end else if (cmd_inh) begin
        inhibit <= 1'b1;
      end else if (adr_go) begin
        if (cnt == CNT_W'(0)) begin
          addr[IO_W-1:0] <= io;
          addr[IO_W]     <= a8;
          col_ptr        <= COL_W'({a8, io});
          cnt            <= CNT_W'(1);
        end else if (cnt == CNT_W'(1)) begin
          addr[2*IO_W:IO_W+1] <= io;
          cnt                 <= CNT_W'(2);
        end else if (cnt == CNT_W'(2)) begin
          addr[AW-1:2*IO_W+1] <= io[IO_W-2:0];
          addr_err            <= io[IO_W-1];
          addr_valid          <= 1'b1;
          cnt                 <= FULL_CNT;
        end else begin
          addr_ovf <= 1'b1;
        end
      end else if (dat_go) begin
        din_stb  <= 1'b1;
        din_byte <= io;
        din_col  <= col_ptr;
        col_ptr  <= (col_ptr == LAST_COL) ? LAST_COL : col_ptr + COL_W'(1);
      end
    end
  end
endmodule

module nand_cmd_addr_latch_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wp_n,
  input logic       busy,
  input logic       cmd_stb,
  input logic [7:0] cmd_op,
  input logic       addr_valid,
  input logic       din_stb,
  input logic [9:0] din_col,
  input logic       addr_err
);
  a_r6_wp_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |-> ($past(wp_n) || !(cmd_op == 8'h80 || cmd_op == 8'h10 ||
                                  cmd_op == 8'h60 || cmd_op == 8'hD0)));
  a_r7_busy_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && $past(busy)) |-> (cmd_op == 8'hFF || cmd_op == 8'h70));
  a_r7_busy_no_data: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> !din_stb);
  a_r9_din_needs_addr: assert property (@(posedge clk) disable iff (!rst_n)
    din_stb |-> addr_valid);
  a_r9_col_cap: assert property (@(posedge clk) disable iff (!rst_n)
    din_col <= 10'd527);
  a_r1_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_stb, din_stb}));
  a_r3_err_after_addr: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_err) |-> addr_valid);
endmodule

bind nand_cmd_addr_latch nand_cmd_addr_latch_chk u_chk (.*);

// File: tb/nand_cmd_addr_latch_tb.sv
module nand_cmd_addr_latch_tb;
  logic clk = 0, rst_n = 0;
  logic ce_n = 1, cle = 0, ale = 0, we_n = 1, re_n = 1, wp_n = 1, busy = 0;
  logic [7:0] io = 0;
  logic cmd_stb, addr_valid, din_stb, addr_err, addr_ovf, inhibit;
  logic [7:0] cmd_op, din_byte;
  logic [23:0] addr;
  logic [9:0] din_col;
  int total = 0, bad = 0;
  bit done = 0;

  logic m_a8 = 0, m_valid = 0, m_err = 0, m_ovf = 0, m_inh = 0;
  logic m_cs, m_ds;
  logic [7:0] m_op = 0, m_db = 0;
  logic [23:0] m_addr = 0;
  logic [9:0] m_dc = 0, m_colp = 0;
  int m_cnt = 0;

  always #4 clk = ~clk;

  nand_cmd_addr_latch u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic bit is_pe(input logic [7:0] d);
    return d == 8'h80 || d == 8'h10 || d == 8'h60 || d == 8'hD0;
  endfunction

  function automatic logic [9:0] next_col(input logic [9:0] c);
    return (c == 10'd527) ? 10'd527 : c + 10'd1;
  endfunction

  task automatic model(input logic c, input logic a, input logic [7:0] d,
                       input logic ce, input logic re);
    m_cs = 0; m_ds = 0;
    if (ce || !re) return;                       // R10
    if (c && !a) begin
      if ((!busy || d == 8'hFF || d == 8'h70) && !(is_pe(d) && !wp_n)) begin
        m_cs = 1; m_op = d; m_cnt = 0; m_valid = 0;
        m_err = 0; m_ovf = 0; m_inh = 0;
        if (d == 8'h00 || d == 8'hFF) m_a8 = 0;  // R4 R8
        if (d == 8'h01) m_a8 = 1;
      end else if (!busy && is_pe(d) && !wp_n) m_inh = 1;
    end else if (!c && a && !busy) begin
      case (m_cnt)
        0: begin m_addr[8:0] = {m_a8, d}; m_colp = {1'b0, m_a8, d}; m_cnt = 1; end
        1: begin m_addr[16:9] = d; m_cnt = 2; end
        2: begin m_addr[23:17] = d[6:0]; m_err = d[7]; m_valid = 1; m_cnt = 3; end
        default: m_ovf = 1;
      endcase
    end else if (!c && !a && !busy && m_valid) begin
      m_ds = 1; m_db = d; m_dc = m_colp; m_colp = next_col(m_colp);
    end
  endtask

  task automatic compare();
    chk("R1 cmd_stb", cmd_stb, m_cs);
    if (m_cs) chk("R1 cmd_op", cmd_op, m_op);
    chk("R2 addr", addr, m_addr);
    chk("R2 addr_valid", addr_valid, m_valid);
    chk("R3 addr_err", addr_err, m_err);
    chk("R5 addr_ovf", addr_ovf, m_ovf);
    chk("R6 inhibit", inhibit, m_inh);
    chk("R9 din_stb", din_stb, m_ds);
    if (m_ds) begin
      chk("R9 din_byte", din_byte, m_db);
      chk("R9 din_col", din_col, m_dc);
    end
  endtask

  task automatic bus_wr(input logic c, input logic a, input logic [7:0] d,
                        input logic ce = 0, input logic re = 1);
    @(negedge clk);
    cle = c; ale = a; io = d; ce_n = ce; re_n = re; we_n = 0;
    @(negedge clk);
    we_n = 1;
    @(negedge clk);
    model(c, a, d, ce, re);
    compare();
  endtask

  task automatic send_addr(input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
    bus_wr(0, 1, b0); bus_wr(0, 1, b1); bus_wr(0, 1, b2);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    m_cs = 0; m_ds = 0;
    compare();                                   // reset state, R4 pointer 0

    // R4: pointer command 01h sets addr[8]
    bus_wr(1, 0, 8'h01);
    send_addr(8'h12, 8'h34, 8'h56);
    chk("R4 addr8 set", addr[8], 1'b1);
    bus_wr(1, 0, 8'h00);
    send_addr(8'hAA, 8'h01, 8'h7F);
    chk("R4 addr8 clear", addr[8], 1'b0);

    // R3 reserved bit, R5 overflow
    bus_wr(1, 0, 8'h80);
    send_addr(8'h01, 8'h02, 8'h83);
    chk("R3 err flag", addr_err, 1'b1);
    bus_wr(0, 1, 8'h99);
    chk("R5 ovf flag", addr_ovf, 1'b1);

    // R9 column saturates at 527
    bus_wr(1, 0, 8'h01);
    send_addr(8'hF0, 8'h00, 8'h00);
    for (int i = 0; i < 300; i++) bus_wr(0, 0, 8'(i));
    chk("R9 col cap", din_col, 10'd527);

    // R6 write protect
    wp_n = 0;
    bus_wr(1, 0, 8'h60);
    chk("R6 inhibit set", inhibit, 1'b1);
    wp_n = 1;

    // R7 busy, R8 reset while busy
    busy = 1;
    bus_wr(0, 0, 8'h55);
    bus_wr(1, 0, 8'h90);
    bus_wr(1, 0, 8'hFF);
    chk("R8 valid cleared", addr_valid, 1'b0);
    busy = 0;

    // R10 deselected / read-enable low
    bus_wr(1, 0, 8'h01, 1'b1, 1'b1);
    bus_wr(1, 0, 8'h01, 1'b0, 1'b0);
    send_addr(8'h00, 8'h00, 8'h00);
    chk("R10 pointer untouched", addr[8], 1'b0);

    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] d;
      int k;
      busy = ($urandom_range(0, 7) == 0);
      wp_n = ($urandom_range(0, 5) != 0);
      k = $urandom_range(0, 9);
      d = 8'($urandom);
      if (k < 2) begin
        case ($urandom_range(0, 8))
          0: d = 8'h00; 1: d = 8'h01; 2: d = 8'h80; 3: d = 8'h10;
          4: d = 8'h60; 5: d = 8'hD0; 6: d = 8'h70; 7: d = 8'hFF;
          default: ;
        endcase
        bus_wr(1, 0, d, ($urandom_range(0, 15) == 0), ($urandom_range(0, 15) != 0));
      end else if (k < 5) begin
        bus_wr(0, 1, d, ($urandom_range(0, 15) == 0), ($urandom_range(0, 15) != 0));
      end else begin
        bus_wr(0, 0, d, ($urandom_range(0, 15) == 0), ($urandom_range(0, 15) != 0));
      end
    end
    busy = 0; wp_n = 1;

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule